// File: doc/BRIEF.md
# Colour Math Blend Stage

This stage sits at the end of a tile-based picture pipeline. Each clock it takes one resolved main-screen pixel, a 15-bit colour and a tag naming the layer that won it, and may combine it with a second colour before the pixel goes on to output. The second operand is the sub-screen pixel when one is present and selected. Otherwise it is a programmable constant colour. The combination works on each 5-bit channel separately. It is either a saturating add or a floor-clamped subtract, and the result can optionally be halved.

Whether the combination is applied to a pixel depends on two conditions. A per-layer participation mask must enable the winning layer. A two-bit window policy must also allow it, given whether the pixel lies inside the window. When math is not applied, the main colour passes through unchanged. The stage has one register and carries a valid strobe alongside the colour.

Top module: `pix_blend`

## Requirements
- R1: Colours are 15 bits: red in bits 4:0, green in bits 9:5, blue in bits 14:10. Each channel is combined independently of the others.
- R2: In add mode (`cfg_subtract`=0, `cfg_halve`=0), each channel result is main plus operand, limited to 31.
- R3: In subtract mode (`cfg_subtract`=1, `cfg_halve`=0), each channel result is main minus operand, limited below at 0.
- R4: With `cfg_halve`=1, add gives (main+operand)>>1 using the full 6-bit sum, and subtract gives max(main-operand,0)>>1. Example: main (r20,g10,b8) add-half operand (r6,g14,b28) gives (r13,g12,b18).
- R5: The operand is `sub_col` when `cfg_use_sub`=1 and `sub_present`=1. In every other case it is `fixed_col`.
- R6: `main_layer` codes are 0..3 for the four backgrounds, 4 for sprites and 5 for the backdrop. Math is allowed only if `cfg_layer_mask` bit [main_layer] is 1. Codes 6 and 7 never allow math.
- R7: `cfg_win_mode` values: 0 means never, 1 means only where `in_window`=1, 2 means only where `in_window`=0, and 3 means always. Math applies only if both this policy and R6 allow it.
- R8: When math does not apply, `out_col` equals `main_col`.
- R9: `out_col` and `out_valid` are registered with one clock of latency. `out_valid` follows `in_valid`, and `out_col` holds its value on cycles where `in_valid`=0.
- R10: A synchronous active-high reset clears `out_col` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| main_col | input | 15 | Main-screen colour |
| main_layer | input | 3 | Layer code of the main pixel |
| sub_col | input | 15 | Sub-screen colour |
| sub_present | input | 1 | A sub-screen layer covers this pixel |
| fixed_col | input | 15 | Constant colour operand |
| in_window | input | 1 | Pixel lies inside the window |
| cfg_subtract | input | 1 | 1 selects subtract, 0 selects add |
| cfg_halve | input | 1 | Halve the combined channels |
| cfg_use_sub | input | 1 | Use the sub-screen pixel as operand when present |
| cfg_layer_mask | input | 6 | Per-layer math enable, indexed by layer code |
| cfg_win_mode | input | 2 | Window policy |
| out_col | output | 15 | Resulting colour |
| out_valid | output | 1 | Output valid |

## Verification
The hardest cases to reach are the channel extremes: an add that lands exactly on 31 or 32, a subtract that lands exactly on 0 or on -1, and the same edges with halving applied. Random colours almost never place all three channels on these boundaries together. The stimulus therefore sweeps every pair of 5-bit values through the red and green channels under all four operation codes. Blue receives a derived mix of the same values. The gating decision is reached by a full walk over all eight layer codes, all four window policies and both window states, under several mask patterns.

// File: rtl/pix_blend_pkg.sv
package pix_blend_pkg;
  typedef enum logic [1:0] {
    WIN_NEVER   = 2'd0,
    WIN_INSIDE  = 2'd1,
    WIN_OUTSIDE = 2'd2,
    WIN_ALWAYS  = 2'd3
  } win_mode_e;
endpackage

// File: rtl/blend_chan.sv
module blend_chan #(
  parameter int W = 5
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  input  logic         halve,
  output logic [W-1:0] y
);
  logic [W:0]   sum;
  logic [W:0]   diff;
  logic [W-1:0] floored;

  always_comb begin
    sum     = {1'b0, a} + {1'b0, b};
    diff    = {1'b0, a} - {1'b0, b};
    floored = diff[W] ? '0 : diff[W-1:0];
    if (do_sub)
      y = halve ? (floored >> 1) : floored;
    else if (halve)
      y = sum[W:1];
    else
      y = sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/blend_gate.sv
module blend_gate
  import pix_blend_pkg::*;
#(
  parameter int NLAYER  = 6,
  parameter int LAYER_W = 3
) (
  input  logic [LAYER_W-1:0] layer,
  input  logic [NLAYER-1:0]  mask,
  input  logic               in_window,
  input  logic [1:0]         win_mode,
  output logic               math_on
);
  logic [NLAYER-1:0] hit;
  logic              win_ok;

  for (genvar i = 0; i < NLAYER; i++) begin : g_hit
    assign hit[i] = mask[i] && (layer == LAYER_W'(i));
  end

  always_comb begin
    case (win_mode_e'(win_mode))
      WIN_NEVER:   win_ok = 1'b0;
      WIN_INSIDE:  win_ok = in_window;
      WIN_OUTSIDE: win_ok = !in_window;
      default:     win_ok = 1'b1;
    endcase
    math_on = win_ok && (|hit);
  end
endmodule

// File: rtl/pix_blend.sv
module pix_blend
  import pix_blend_pkg::*;
#(
  parameter int CH_W    = 5,
  parameter int NCH     = 3,
  parameter int NLAYER  = 6,
  parameter int LAYER_W = 3,
  localparam int COL_W  = CH_W * NCH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [COL_W-1:0]   main_col,
  input  logic [LAYER_W-1:0] main_layer,
  input  logic [COL_W-1:0]   sub_col,
  input  logic               sub_present,
  input  logic [COL_W-1:0]   fixed_col,
  input  logic               in_window,
  input  logic               cfg_subtract,
  input  logic               cfg_halve,
  input  logic               cfg_use_sub,
  input  logic [NLAYER-1:0]  cfg_layer_mask,
  input  logic [1:0]         cfg_win_mode,
  output logic [COL_W-1:0]   out_col,
  output logic               out_valid
);
  logic [COL_W-1:0] operand;
  logic [COL_W-1:0] mixed;
  logic             math_on;

  assign operand = (cfg_use_sub && sub_present) ? sub_col : fixed_col;

  blend_gate #(.NLAYER(NLAYER), .LAYER_W(LAYER_W)) u_gate (
    .layer     (main_layer),
    .mask      (cfg_layer_mask),
    .in_window (in_window),
    .win_mode  (cfg_win_mode),
    .math_on   (math_on)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0] m_ch;
    logic [CH_W-1:0] y_ch;
    assign m_ch = main_col[c*CH_W +: CH_W];

    blend_chan #(.W(CH_W)) u_chan (
      .a      (m_ch),
      .b      (operand[c*CH_W +: CH_W]),
      .do_sub (cfg_subtract),
      .halve  (cfg_halve),
      .y      (y_ch)
    );
    assign mixed[c*CH_W +: CH_W] = y_ch;

    assert_add_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (!cfg_subtract && !cfg_halve) |-> (y_ch >= m_ch));
    assert_sub_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
      cfg_subtract |-> (y_ch <= m_ch));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_col   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_col <= math_on ? mixed : main_col;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_col)));
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !math_on) |=> (out_col == $past(main_col)));
  assert_win_never_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_win_mode == 2'd0) |=> (out_col == $past(main_col)));
endmodule

// File: tb/pix_blend_test.sv
module pix_blend_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [14:0] main_col = '0, sub_col = '0, fixed_col = '0;
  logic [2:0]  main_layer = '0;
  logic        sub_present = 1'b0, in_window = 1'b0;
  logic        cfg_subtract = 1'b0, cfg_halve = 1'b0, cfg_use_sub = 1'b0;
  logic [5:0]  cfg_layer_mask = '0;
  logic [1:0]  cfg_win_mode = '0;
  logic [14:0] out_col;
  logic        out_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pix_blend uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .main_col(main_col),
    .main_layer(main_layer), .sub_col(sub_col), .sub_present(sub_present),
    .fixed_col(fixed_col), .in_window(in_window), .cfg_subtract(cfg_subtract),
    .cfg_halve(cfg_halve), .cfg_use_sub(cfg_use_sub),
    .cfg_layer_mask(cfg_layer_mask), .cfg_win_mode(cfg_win_mode),
    .out_col(out_col), .out_valid(out_valid)
  );

  function automatic logic [4:0] ch_op(input int a, input int b, input bit s, input bit h);
    int r;
    if (s) begin
      r = a - b;
      if (r < 0) r = 0;
      if (h) r = r / 2;
    end else begin
      r = a + b;
      if (h) r = r / 2;
      else if (r > 31) r = 31;
    end
    return r[4:0];
  endfunction

  function automatic logic [14:0] model();
    logic [14:0] op, res;
    bit layer_ok, win_ok;
    op = (cfg_use_sub && sub_present) ? sub_col : fixed_col;
    layer_ok = (main_layer < 6) && cfg_layer_mask[main_layer];
    case (cfg_win_mode)
      2'd0: win_ok = 0;
      2'd1: win_ok = in_window;
      2'd2: win_ok = !in_window;
      default: win_ok = 1;
    endcase
    if (!(layer_ok && win_ok)) return main_col;
    for (int c = 0; c < 3; c++)
      res[c*5 +: 5] = ch_op(int'(main_col[c*5 +: 5]), int'(op[c*5 +: 5]),
                            cfg_subtract, cfg_halve);
    return res;
  endfunction

  task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input string req);
    logic [14:0] exp;
    exp = model();
    in_valid = 1'b1;
    @(negedge clk);
    check(req, out_col, exp);
    check("R9 valid", {14'd0, out_valid}, 15'd1);
  endtask

  function automatic logic [14:0] pack(input int r, input int g, input int b);
    pack = {b[4:0], g[4:0], r[4:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_col", out_col, 15'd0);
    check("R10 out_valid", {14'd0, out_valid}, 15'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R4: exhaustive channel pairs under all four operations
    cfg_use_sub = 1; sub_present = 1; cfg_layer_mask = 6'h3F;
    cfg_win_mode = 2'd3; main_layer = 3'd0;
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++) begin
          cfg_subtract = op[0]; cfg_halve = op[1];
          main_col = pack(a, b, (a + 3*b) % 32);
          sub_col  = pack(b, a, (a * b) % 32);
          fixed_col = pack(31, 31, 31);
          apply(op[1] ? "R1 R4 halve" : (op[0] ? "R1 R3 sub" : "R1 R2 add"));
        end

    // R4 worked example
    cfg_subtract = 0; cfg_halve = 1;
    main_col = pack(20, 10, 8); sub_col = pack(6, 14, 28);
    in_valid = 1; @(negedge clk);
    check("R4 example", out_col, pack(13, 12, 18));

    // R5 operand selection
    cfg_halve = 0;
    for (int u = 0; u < 2; u++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 4; k++) begin
          cfg_use_sub = u[0]; sub_present = p[0];
          main_col = pack(k * 5, 3, 10);
          sub_col = pack(1, 2, 3);
          fixed_col = pack(7, 20 + k, 9);
          apply("R5 operand");
        end

    // R6 R7 R8: gate sweep
    cfg_use_sub = 1; sub_present = 1;
    for (int m = 0; m < 4; m++)
      for (int t = 0; t < 8; t++)
        for (int w = 0; w < 4; w++)
          for (int iw = 0; iw < 2; iw++) begin
            case (m)
              0: cfg_layer_mask = 6'h3F;
              1: cfg_layer_mask = 6'h15;
              2: cfg_layer_mask = 6'h2A;
              default: cfg_layer_mask = 6'h00;
            endcase
            main_layer = t[2:0]; cfg_win_mode = w[1:0]; in_window = iw[0];
            cfg_subtract = t[0];
            main_col = pack(12 + t, 9, 30 - w);
            sub_col = pack(4, 25, 6);
            apply("R6 R7 R8 gating");
          end

    // R9 hold while idle
    in_valid = 1; cfg_win_mode = 2'd0; main_col = pack(3, 4, 5);
    @(negedge clk);
    check("R9 load", out_col, pack(3, 4, 5));
    in_valid = 0; main_col = pack(30, 1, 17);
    @(negedge clk);
    check("R9 hold col", out_col, pack(3, 4, 5));
    check("R9 idle valid", {14'd0, out_valid}, 15'd0);
    @(negedge clk);
    check("R9 hold col 2", out_col, pack(3, 4, 5));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule